// File: doc/BRIEF.md
# Supervisory Watchdog Timer

A countdown watchdog that a host must keep alive. Software arms it by writing a configuration byte that holds a multiplier, a resolution code and a steering bit. The multiplier times the resolution gives a timeout, counted in ticks of a prescaled time base that arrives on an input pin. The host keeps the countdown from running out in one of two ways: it toggles a service pin (either edge counts), or it writes the configuration byte again.

When the countdown runs out, the block does four things:
- It sets a sticky, read-only timeout flag.
- It clears the configuration byte, which disarms the watchdog.
- If the steering bit is set, it raises a reset pulse of fixed length.
- If the steering bit is clear, it raises a held interrupt.

The interrupt shares an output with a frequency-test wave, and a pending interrupt takes precedence over that wave. A read strobe on the flags register acknowledges the timeout: it clears both the flag and the held interrupt.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset, `wdt_flag_o`, `irq_ft_o` and `rst_pulse_o` are low, and the configuration byte is zero, so no timeout can occur.
- R2: A write to address `CFG_ADDR` stores the byte with these fields:
  - bits [4:0]: multiplier M;
  - bits [6:5]: resolution code K;
  - bit 7: steering bit.
  The write loads a countdown of M·4^K time-base ticks. The codes K = 0, 1, 2 and 3 give steps of 1, 4, 16 and 64 ticks. Absent service, the flag rises after the cycle carrying the M·4^K-th tick, and not before.
- R3: When M is zero, the watchdog is disabled, and no number of ticks produces a timeout.
- R4: A write to `CFG_ADDR` restarts the countdown from the newly written value. A write to any other address leaves the countdown unchanged.
- R5: Each rising or falling edge of `wdi_i` reloads the countdown from the current configuration. The reload takes effect after `SYNC_STAGES`+1 clock cycles.
- R6: A timeout sets `wdt_flag_o`. A one-cycle `flags_rd_i` strobe clears the flag. If a timeout and a strobe fall in the same cycle, the flag is set.
- R7: A timeout clears the configuration byte. After a timeout, further `wdi_i` edges and ticks produce no new timeout until the byte is written again.
- R8: A timeout with the steering bit set drives `rst_pulse_o` high for exactly `RST_CYCLES` clock cycles, and it leaves the interrupt low.
- R9: A timeout with the steering bit clear drives `irq_ft_o` high, and it stays high until a `flags_rd_i` strobe. Such a timeout produces no reset pulse.
- R10: While no interrupt is pending, `irq_ft_o` equals `ft_en_i & ft_wave_i`. While an interrupt is pending, `irq_ft_o` is high whatever the test wave does.
- R11: A configuration write in the same cycle as the final tick takes precedence. In that case no timeout occurs, and the countdown reloads from the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled time-base tick, one cycle per tick |
| wdi_i | input | 1 | Service pin; either edge reloads the countdown |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data |
| flags_rd_i | input | 1 | Flags-register read strobe; acknowledges a timeout |
| ft_en_i | input | 1 | Frequency-test output enable |
| ft_wave_i | input | 1 | Frequency-test waveform |
| wdt_flag_o | output | 1 | Sticky timeout flag |
| irq_ft_o | output | 1 | Held interrupt, or the frequency-test wave when no interrupt is pending |
| rst_pulse_o | output | 1 | Fixed-length reset pulse |

## Verification
The bench uses the default parameters: 5-bit multiplier, 2-bit resolution, `RST_CYCLES` = 8 and a two-stage service synchronizer. These defaults keep the longest countdown at 1984 ticks. That is short enough for the bench to sweep every pair of multiplier and resolution code, with both steering choices. Each sweep point checks the exact tick on which the timeout lands, the routing of the timeout, and the pulse length. Separate sequences cover service by pin and by write, the precedence of write over final tick, the precedence of flag-set over acknowledge, and the mux with the frequency-test wave.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg
// Field layout of the watchdog configuration byte and the countdown width.
// Assumes an 8-bit configuration byte; the multiplier and resolution widths
// below fix the largest countdown the counter must hold.
package wdt_pkg;
    localparam int MULT_W = 5;
    localparam int RES_W  = 2;
    // largest shift is 2*(2^RES_W - 1)
    localparam int MAX_SHIFT = 2 * ((1 << RES_W) - 1);
    localparam int CNT_W  = MULT_W + MAX_SHIFT;

    typedef struct packed {
        logic              steer;   // 1: timeout to reset, 0: to interrupt
        logic [RES_W-1:0]  res;     // resolution code
        logic [MULT_W-1:0] mult;    // multiplier, 0 disables
    } wdt_cfg_t;

    // Countdown length in base ticks: mult * 4^res
    function automatic logic [CNT_W-1:0] load_ticks(input wdt_cfg_t c);
        logic [CNT_W-1:0] m;
        m = {{(CNT_W-MULT_W){1'b0}}, c.mult};
        return m << {c.res, 1'b0};
    endfunction
endpackage

// File: rtl/wdt_wdi_edge.sv
// Module wdt_wdi_edge
// Synchronizes the asynchronous service pin through SYNC_STAGES flops and
// flags a one-cycle pulse on either edge of the synchronized level.
// Assumes SYNC_STAGES >= 1; the pin reads low during reset.
module wdt_wdi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wdi_i,
    output logic edge_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // first synchronizer stage samples the pin
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= wdi_i;
    end

    // remaining stages
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
        end
    end

    // previous synchronized level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/wdt_cfg_reg.sv
// Module wdt_cfg_reg
// Holds the configuration byte: loaded by a write to CFG_ADDR, cleared when
// the watchdog expires. A write in the expiry cycle wins over the clear.
// Assumes the write port is single-cycle with no read-back.
module wdt_cfg_reg
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CFG_ADDR = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              expire_i,
    output logic              wr_hit_o,
    output wdt_cfg_t          cfg_o,
    output wdt_cfg_t          next_cfg_o
);
    wdt_cfg_t cfg_q;

    assign wr_hit_o   = wr_en_i && (wr_addr_i == ADDR_W'(CFG_ADDR));
    assign next_cfg_o = wr_hit_o ? wdt_cfg_t'(wr_data_i) : cfg_q;
    assign cfg_o      = cfg_q;

    // configuration storage: write first, then clear on expiry
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_q <= '0;
        else if (wr_hit_o) cfg_q <= wdt_cfg_t'(wr_data_i);
        else if (expire_i) cfg_q <= '0;
    end

    // R7: expiry without a competing write leaves the watchdog disarmed
    p_clear_after_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !wr_hit_o) |=> (cfg_q.mult == '0));
endmodule

// File: rtl/wdt_countdown.sv
// Module wdt_countdown
// Tick counter. A reload copies load_val (zero means idle); each tick
// decrements a nonzero count and the tick that takes it from one to zero
// is the expiry. A reload in the same cycle overrides the tick.
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] MAX_LOAD =
        CNT_W'(((1 << MULT_W) - 1)) << MAX_SHIFT;

    logic [CNT_W-1:0] cnt_q;

    assign expire_o = tick_i && !reload_i && (cnt_q == CNT_W'(1));

    // count register: reload has priority over ticking
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (reload_i)                cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
    end

    // R2: the count never exceeds the largest programmable timeout
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_LOAD);
endmodule

// File: rtl/wdt_out_stage.sv
// Module wdt_out_stage
// Timeout consequences: sticky flag, held interrupt or fixed-length reset
// pulse, and the interrupt/frequency-test output mux.
// Assumes steer_i is the configuration in force in the expiry cycle.
module wdt_out_stage #(
    parameter int RST_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic steer_i,
    input  logic flags_rd_i,
    input  logic ft_en_i,
    input  logic ft_wave_i,
    output logic wdt_flag_o,
    output logic irq_ft_o,
    output logic rst_pulse_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic            flag_q;
    logic            irq_q;
    logic [RC_W-1:0] rst_cnt_q;

    // sticky flag: set wins over read-clear
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (expire_i)   flag_q <= 1'b1;
        else if (flags_rd_i) flag_q <= 1'b0;
    end

    // held interrupt for timeouts steered away from reset
    always_ff @(posedge clk) begin
        if (!rst_n)                    irq_q <= 1'b0;
        else if (expire_i && !steer_i) irq_q <= 1'b1;
        else if (flags_rd_i)           irq_q <= 1'b0;
    end

    // reset pulse length counter
    always_ff @(posedge clk) begin
        if (!rst_n)                   rst_cnt_q <= '0;
        else if (expire_i && steer_i) rst_cnt_q <= RC_W'(RST_CYCLES);
        else if (rst_cnt_q != '0)     rst_cnt_q <= rst_cnt_q - RC_W'(1);
    end

    assign wdt_flag_o  = flag_q;
    assign rst_pulse_o = (rst_cnt_q != '0);
    assign irq_ft_o    = irq_q | (ft_en_i & ft_wave_i);

    // R6: a timeout always leaves the flag set
    p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> wdt_flag_o);
    // R8: reset-steered timeout starts the pulse
    p_rst_on_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && steer_i) |=> rst_pulse_o);
    // R9: interrupt held until acknowledged
    p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !flags_rd_i) |=> irq_q);
    // R10: pending interrupt dominates the test wave at the pin
    p_irq_over_ft_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_i && !steer_i) |=> irq_ft_o);
endmodule

// File: rtl/wdt_supervisor.sv
// Module wdt_supervisor
// Top of the supervisory watchdog: service-pin edge detection, configuration
// register, tick countdown and output stage. tick_i is a prescaled time base
// supplied from outside; one cycle high per tick.
module wdt_supervisor
    import wdt_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CFG_ADDR    = 7,
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wdi_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic              flags_rd_i,
    input  logic              ft_en_i,
    input  logic              ft_wave_i,
    output logic              wdt_flag_o,
    output logic              irq_ft_o,
    output logic              rst_pulse_o
);
    logic             wdi_edge;
    logic             wr_hit;
    logic             expire;
    logic             reload;
    wdt_cfg_t         cfg;
    wdt_cfg_t         next_cfg;
    logic [CNT_W-1:0] load_val;

    wdt_wdi_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .wdi_i(wdi_i), .edge_o(wdi_edge)
    );

    wdt_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) cfg_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .expire_i(expire), .wr_hit_o(wr_hit),
        .cfg_o(cfg), .next_cfg_o(next_cfg)
    );

    assign reload   = wr_hit | wdi_edge;
    assign load_val = load_ticks(next_cfg);

    wdt_countdown cnt_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .reload_i(reload), .load_val_i(load_val), .expire_o(expire)
    );

    wdt_out_stage #(.RST_CYCLES(RST_CYCLES)) out_i (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .steer_i(cfg.steer),
        .flags_rd_i(flags_rd_i), .ft_en_i(ft_en_i), .ft_wave_i(ft_wave_i),
        .wdt_flag_o(wdt_flag_o), .irq_ft_o(irq_ft_o), .rst_pulse_o(rst_pulse_o)
    );

    // R3: a timeout can only come from an armed configuration
    p_no_expire_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (cfg.mult != '0));
endmodule

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb_top;
    localparam int ADDR_W = 4;
    localparam int CFG_ADDR = 7;
    localparam int RST_CYCLES = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_i = 0, wdi_i = 0, wr_en_i = 0, flags_rd_i = 0;
    logic ft_en_i = 0, ft_wave_i = 0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [7:0] wr_data_i = '0;
    logic wdt_flag_o, irq_ft_o, rst_pulse_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    wdt_supervisor #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR),
                     .RST_CYCLES(RST_CYCLES), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wdi_i(wdi_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .flags_rd_i(flags_rd_i), .ft_en_i(ft_en_i), .ft_wave_i(ft_wave_i),
        .wdt_flag_o(wdt_flag_o), .irq_ft_o(irq_ft_o), .rst_pulse_o(rst_pulse_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 0;
    endtask

    task automatic ack();
        flags_rd_i = 1;
        @(negedge clk);
        flags_rd_i = 0;
    endtask

    // apply n consecutive ticks; returns 1 if the flag rose during them
    task automatic ticks(input int n, output bit seen);
        seen = 0;
        tick_i = 1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (wdt_flag_o) seen = 1;
        end
        tick_i = 0;
    endtask

    function automatic logic [7:0] cfg_byte(input int m, input int r, input int s);
        return {s[0], r[1:0], m[4:0]};
    endfunction

    initial begin
        bit seen;
        int width;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 flag", wdt_flag_o, 0);
        check("R1 irq", irq_ft_o, 0);
        check("R1 rst", rst_pulse_o, 0);
        ticks(100, seen);
        check("R1 idle after reset", seen, 0);

        // R2/R8/R9 sweep over all multiplier/resolution pairs
        for (int r = 0; r < 4; r++) begin
            for (int m = 0; m < 32; m++) begin
                int n, s;
                s = (m + r) % 2;
                n = m * (4 ** r);
                wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(m, r, s));
                if (m == 0) begin
                    ticks(70, seen);
                    check("R3 disabled", seen, 0);
                end else begin
                    if (n > 1) begin
                        ticks(n - 1, seen);
                        check("R2 no early expiry", seen, 0);
                    end
                    ticks(1, seen);
                    check("R2 expiry on last tick", wdt_flag_o, 1);
                    check(s ? "R8 no irq" : "R9 irq raised", irq_ft_o, s ? 0 : 1);
                    if (s) begin
                        width = 0;
                        while (rst_pulse_o && width < 100) begin
                            width++;
                            @(negedge clk);
                        end
                        check("R8 pulse width", width, RST_CYCLES);
                    end else begin
                        check("R9 no reset pulse", rst_pulse_o, 0);
                        repeat (3) @(negedge clk);
                        check("R9 irq held", irq_ft_o, 1);
                    end
                    ack();
                    check("R6 flag cleared by read", wdt_flag_o, 0);
                    check("R9 irq cleared by read", irq_ft_o, 0);
                end
            end
        end

        // R7: disarmed after expiry
        wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(2, 0, 0));
        ticks(2, seen);
        ack();
        wdi_i = 1; repeat (4) @(negedge clk);
        ticks(200, seen);
        check("R7 no retrigger", seen, 0);

        // R4: restart by write, other address ignored
        wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(3, 0, 0));
        ticks(2, seen);
        wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(3, 0, 0));
        ticks(2, seen);
        check("R4 restart by write", seen, 0);
        wr(4'd3, cfg_byte(3, 0, 0));
        ticks(1, seen);
        check("R4 other address ignored", wdt_flag_o, 1);
        ack();

        // R5: service pin edges reload (falling, then rising)
        wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(5, 0, 0));
        ticks(4, seen);
        wdi_i = 0; repeat (4) @(negedge clk);
        ticks(4, seen);
        check("R5 falling edge reload", seen, 0);
        wdi_i = 1; repeat (4) @(negedge clk);
        ticks(4, seen);
        check("R5 rising edge reload", seen, 0);
        ticks(1, seen);
        check("R5 expiry after reload", wdt_flag_o, 1);
        ack();

        // R11: write in final-tick cycle wins
        wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(1, 0, 0));
        tick_i = 1; wr(CFG_ADDR[ADDR_W-1:0], cfg_byte(3, 0, 0)); tick_i = 0;
        check("R11 write beats final tick", wdt_flag_o, 0);
        ticks(2, seen);
        check("R11 reload from new byte", seen, 0);
        // R6: expiry and read strobe in same cycle, set wins
        flags_rd_i = 1;
        ticks(1, seen);
        flags_rd_i = 0;
        check("R6 set beats clear", wdt_flag_o, 1);

        // R10: pending interrupt dominates the test wave
        ft_en_i = 1; ft_wave_i = 0;
        @(negedge clk);
        check("R10 irq over wave low", irq_ft_o, 1);
        ack();
        for (int k = 0; k < 4; k++) begin
            ft_wave_i = k[0]; ft_en_i = k[1];
            @(negedge clk);
            check("R10 wave passthrough", irq_ft_o, k[0] & k[1]);
        end
        ft_en_i = 0;
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule